// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands (32 bits each by default) and gives their full double-width product. It works one bit of the multiplier operand per clock. A single product register holds the multiplier operand in its low half. On each step the high half takes the multiplicand through a carry-select adder when the register's lowest bit is set. The register then moves right one place and the adder's carry-out enters at the top.

The adder shares its logic between its two speculative chains. Each block forms its propagate and generate terms once. Both carry-in assumptions (0 and 1) reuse those terms, so a single XOR per bit feeds both sum candidates. The real block carry then picks one of the two results. A host pulses `start` with both operands present, watches `busy`, and reads `product_o` when `done_o` pulses. The product stays on the output until the next accepted start.

Top module: `mul_shift_add`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the block returns after that edge to idle with `busy_o`=0, `done_o`=0 and `product_o`=0.
- R2: A `start` sampled high while `busy_o` is low is accepted. `busy_o` is high after that same edge.
- R3: After an accepted start, `busy_o` stays high for exactly 32 cycles. `done_o` is high for exactly one cycle, in the cycle after the 32nd step, and `busy_o` is low in that cycle.
- R4: When `done_o` is high, `product_o` equals the full 64-bit unsigned product of the operands latched at the accepted start.
- R5: A `start` that arrives while `busy_o` is high is ignored. The latched operands, the result and the 32-cycle timing are unchanged.
- R6: While the block is idle and no start is accepted, `product_o` holds its value.
- R7: In a step whose product-register bit 0 is 1, the adder gives the 33-bit sum of the upper half and the multiplicand. That sum's carry-out becomes bit 63 after the shift. The boundary case 0xFFFFFFFF × 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R8: A zero operand gives a zero product. An operand equal to one gives the other operand, zero-extended.
- R9: `product_o` shows the product register at all times. After an accepted start it holds {32'h0, multiplier}. In a step whose bit 0 is 0, the register shifts right with 0 entering bit 63. So with a zero multiplicand, `product_o` after k steps equals multiplier >> k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication |
| mcand_i | input | 32 | Multiplicand operand, sampled when start is accepted |
| mplier_i | input | 32 | Multiplier operand, sampled when start is accepted |
| busy_o | output | 1 | High while the 32 steps run |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| product_o | output | 64 | Product register contents |

## Verification
The assertions assume that `rst` is held high for at least one rising edge before any checked activity, and that `start`, `mcand_i` and `mplier_i` carry known 0/1 values at every edge. They assume nothing about when `start` arrives: a start during a run must be absorbed silently, and the properties on operand stability and run length cover that case. The stimulus changes inputs only on falling edges and always drives defined values. It deliberately raises `start` inside a run and holds the inputs noisy while the block is idle.

// File: rtl/mul_pkg.sv
package mul_pkg;

  localparam int unsigned OP_W_DEF  = 32;
  localparam int unsigned BLK_W_DEF = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;

endpackage

// File: rtl/mul_cbl_block.sv
module mul_cbl_block #(
  parameter int unsigned BW = 4
) (
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [BW-1:0] sum0_o,
  output logic [BW-1:0] sum1_o,
  output logic          cout0_o,
  output logic          cout1_o
);

  // Ripple carries into each bit position, for a given carry-in,
  // using only the shared propagate and generate terms.
  function automatic logic [BW:0] chain(input logic [BW-1:0] p,
                                       input logic [BW-1:0] g,
                                       input logic          cin);
    logic [BW:0] c;
    c[0] = cin;
    for (int i = 0; i < BW; i++) begin
      c[i+1] = g[i] | (p[i] & c[i]);
    end
    return c;
  endfunction

  logic [BW-1:0] prop;
  logic [BW-1:0] gen;
  logic [BW:0]   car0;
  logic [BW:0]   car1;

  assign prop = a_i ^ b_i;
  assign gen  = a_i & b_i;

  assign car0 = chain(prop, gen, 1'b0);
  assign car1 = chain(prop, gen, 1'b1);

  // Bit 0 of the carry-in-1 sum is just the inverse of the shared XOR.
  assign sum0_o  = prop ^ car0[BW-1:0];
  assign sum1_o  = prop ^ car1[BW-1:0];
  assign cout0_o = car0[BW];
  assign cout1_o = car1[BW];

endmodule

// File: rtl/mul_csel_adder.sv
module mul_csel_adder #(
  parameter int unsigned W  = mul_pkg::OP_W_DEF,
  parameter int unsigned BW = mul_pkg::BLK_W_DEF
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  localparam int unsigned NB = W / BW;

  logic [NB:0] blk_c;

  assign blk_c[0] = cin_i;

  for (genvar k = 0; k < NB; k++) begin : g_blk
    logic [BW-1:0] s0;
    logic [BW-1:0] s1;
    logic          c0;
    logic          c1;

    mul_cbl_block #(.BW(BW)) u_blk (
      .a_i    (a_i[k*BW +: BW]),
      .b_i    (b_i[k*BW +: BW]),
      .sum0_o (s0),
      .sum1_o (s1),
      .cout0_o(c0),
      .cout1_o(c1)
    );

    assign sum_o[k*BW +: BW] = blk_c[k] ? s1 : s0;
    assign blk_c[k+1]        = blk_c[k] ? c1 : c0;
  end

  assign cout_o = blk_c[NB];

endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl #(
  parameter int unsigned STEPS = mul_pkg::OP_W_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import mul_pkg::*;

  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign busy_o    = (state_q == ST_RUN);
  assign load_o    = start && !busy_o;
  assign step_o    = busy_o;
  assign last_step = step_o && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_step;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (last_step) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mul_shift_dp.sv
module mul_shift_dp #(
  parameter int unsigned W  = mul_pkg::OP_W_DEF,
  parameter int unsigned BW = mul_pkg::BLK_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o,
  output logic [W-1:0]   mcand_o,
  output logic           add_en_o,
  output logic [W-1:0]   add_sum_o,
  output logic           add_cout_o
);

  // One shift-right step: carry on top, sum below it, low half moves down.
  function automatic logic [2*W-1:0] shift_in(input logic [2*W-1:0] cur,
                                              input logic [W-1:0]   hi_sum,
                                              input logic           cy);
    return {cy, hi_sum, cur[W-1:1]};
  endfunction

  logic [2*W-1:0] prod_q;
  logic [W-1:0]   mcand_q;
  logic [W-1:0]   addend;

  assign add_en_o = prod_q[0];
  assign addend   = add_en_o ? mcand_q : '0;

  mul_csel_adder #(.W(W), .BW(BW)) u_add (
    .a_i   (prod_q[2*W-1:W]),
    .b_i   (addend),
    .cin_i (1'b0),
    .sum_o (add_sum_o),
    .cout_o(add_cout_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      prod_q  <= {{W{1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (step_i) begin
      prod_q  <= shift_in(prod_q, add_sum_o, add_cout_o);
    end
  end

  assign prod_o  = prod_q;
  assign mcand_o = mcand_q;

endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int unsigned W  = 32,
  parameter int unsigned BW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);

  // Named internal events, visible to the bound checker.
  logic           load;
  logic           step_fire;
  logic [2*W-1:0] prod_q;
  logic [W-1:0]   mcand_q;
  logic           add_en;
  logic [W-1:0]   add_sum;
  logic           add_cout;

  mul_seq_ctrl #(.STEPS(W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load_o(load),
    .step_o(step_fire),
    .busy_o(busy_o),
    .done_o(done_o)
  );

  mul_shift_dp #(.W(W), .BW(BW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .step_i    (step_fire),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .prod_o    (prod_q),
    .mcand_o   (mcand_q),
    .add_en_o  (add_en),
    .add_sum_o (add_sum),
    .add_cout_o(add_cout)
  );

  assign product_o = prod_q;

endmodule

// File: rtl/mul_shift_add_chk.sv
module mul_shift_add_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned BW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o,
  input logic           step_fire,
  input logic [2*W-1:0] prod_q,
  input logic [W-1:0]   mcand_q,
  input logic           add_en,
  input logic [W-1:0]   add_sum,
  input logic           add_cout
);

  localparam int unsigned RCW = $clog2(W + 2) + 1;

  // Counts busy cycles since the last accepted start.
  logic [RCW-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (start && !busy_o) run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
  end

  p_idle_after_rst_r1: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && product_o == '0));

  p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_o) |=> busy_o);

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_run_length_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run_cnt == RCW'(W)));

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (run_cnt < RCW'(W)));

  p_mcand_held_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(mcand_q));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start) |=> $stable(product_o));

  p_adder_sum_r7: assert property (@(posedge clk) disable iff (rst)
    (step_fire && add_en) |->
      ({add_cout, add_sum} == ({1'b0, prod_q[2*W-1:W]} + {1'b0, mcand_q})));

  p_carry_top_r7: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> (product_o[2*W-1] == $past(add_cout)));

  p_plain_shift_r9: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !add_en) |=> (product_o == {1'b0, $past(prod_q[2*W-1:1])}));

endmodule

bind mul_shift_add mul_shift_add_chk #(.W(W), .BW(BW)) u_chk (.*);

// File: tb/sim_mul_shift_add.sv
`timescale 1ns/1ps
module sim_mul_shift_add;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy;
  logic          done;
  logic [63:0]   product;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mul_shift_add u0 (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .busy_o   (busy),
    .done_o   (done),
    .product_o(product)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: compares each completed product against the scoreboard.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected done", product, 64'h0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(product == e, t, product, e);
      end
    end
  end

  // Driver: issues one multiplication, optionally pokes start mid-run.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag, input int poke_at);
    int n;
    while (busy) @(negedge clk);
    mcand = a;
    mplier = b;
    start = 1'b1;
    exp_q.push_back(64'(a) * 64'(b));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'h1);
    n = 0;
    while (!done && n < 40) begin
      if (n == poke_at) begin
        start = 1'b1;
        mcand = ~a;
        mplier = b ^ 32'h5A5A_0001;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    check(n == W, "R3 latency", 64'(n), 64'(W));
    check(busy == 1'b0, "R3 busy low at done", 64'(busy), 64'h0);
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle", 64'(done), 64'h0);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", 64'(cycles), 64'h0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", 64'(busy), 64'h0);
    check(done == 1'b0, "R1 reset done", 64'(done), 64'h0);
    check(product == 64'h0, "R1 reset product", product, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    // R8 zero and one
    run_op(32'h0, 32'h1234_5678, "R8 zero x value", -1);
    run_op(32'hDEAD_BEEF, 32'h0, "R8 value x zero", -1);
    run_op(32'h1, 32'hCAFE_F00D, "R8 one x value", -1);
    run_op(32'h8765_4321, 32'h1, "R8 value x one", -1);

    // R7 carry boundary
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 max x max", -1);
    check(product == 64'hFFFF_FFFE_0000_0001, "R7 max product value", product,
          64'hFFFF_FFFE_0000_0001);
    run_op(32'hFFFF_FFFF, 32'h8000_0001, "R7 carry chain", -1);

    // R6 hold while idle with noisy inputs
    begin
      logic [63:0] held;
      held = product;
      for (int i = 0; i < 6; i++) begin
        mcand = $urandom;
        mplier = $urandom;
        @(negedge clk);
      end
      check(product == held, "R6 idle hold", product, held);
    end

    // R5 start during run ignored
    run_op(32'h0001_2345, 32'h0F0F_0F0F, "R5 ignored start", 5);
    run_op(32'hABCD_0000, 32'h0000_FFFF, "R5 ignored start late", 30);

    // R9 plain shifts with zero multiplicand
    begin
      logic [W-1:0] x;
      x = 32'hB6D1_93A7;
      while (busy) @(negedge clk);
      mcand = '0;
      mplier = x;
      start = 1'b1;
      exp_q.push_back(64'h0);
      tag_q.push_back("R9 zero mcand result");
      @(negedge clk);
      start = 1'b0;
      check(product == {32'h0, x}, "R9 load image", product, {32'h0, x});
      for (int k = 1; k <= 3; k++) begin
        @(negedge clk);
        check(product == 64'(x >> k), "R9 shift step", product, 64'(x >> k));
      end
      while (busy) @(negedge clk);
      @(negedge clk);
    end

    // R4 random pairs
    for (int i = 0; i < 40; i++) begin
      run_op($urandom, $urandom, "R4 random pair", -1);
    end

    // R1 reset mid-run
    mcand = 32'h1111_2222;
    mplier = 32'h3333_4444;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 reset mid-run busy", 64'(busy), 64'h0);
    check(product == 64'h0, "R1 reset mid-run product", product, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    run_op(32'h0000_0003, 32'h0000_0007, "R4 after reset", -1);

    check(exp_q.size() == 0, "R4 scoreboard drained", 64'(exp_q.size()), 64'h0);
    finish_run();
  end

endmodule